// File: doc/BRIEF.md
# Phase-Locked One-Per-Period Sampler

The block takes two 14-bit sample streams captured at the same instants on every clock and keeps one sample for each period of the input waveform. A divider of ratio M selects the kept clock. M equals the clock rate divided by the input frequency. M is 1 when the input runs at or above the clock rate and is sub-sampled. The kept sample of channel 1 is the phase error itself. A proportional-integral controller turns it into a signed 14-bit word for a DAC. That DAC steers an external generator, so the kept sample is pulled onto the zero crossing of the waveform.

A record-point input chooses what is recorded. At the zero point, the locking sample itself is recorded. At the peak point, a sample a quarter period later is recorded, while the loop still locks on the zero crossing. The recorded value is always channel 1 minus channel 2, which removes noise shared by both converters. Recording fills a fixed-length capture memory through a write port. Each capture begins with a start pulse and ends with a done flag. A lock flag reports that the error has stayed small for a programmed number of kept samples.

Top module: `psync_sampler`

## Requirements
- R1: A period counter runs from 0 to M-1 and then wraps, where M is `div_m`, and a value of 0 acts as 1. The count-0 clock is the kept (locking) clock. The first kept clock is the third clock edge after `rst_n` rises.
- R2: On each kept clock, with e = `ch1_in` as a signed value, the integrator becomes I + (e >>> `ki_shift`). `dac_word` becomes I_new + (e >>> `kp_shift`). Both take effect on the edge that samples e. Between kept clocks `dac_word` holds.
- R3: The integrator saturates at the signed 18-bit limits (-131072 and 131071) instead of wrapping. `dac_word` is clamped to the signed 14-bit range from -8192 to 8191.
- R4: With `rec_peak` = 0, the recorded sample is the one at count 0. With `rec_peak` = 1, it is the one at count floor(M/4). The locking sample stays at count 0 in both cases.
- R5: The recorded value is the 15-bit signed difference `ch1_in` - `ch2_in`, taken on the recorded clock.
- R6: On each kept clock, the magnitude of e is compared with `lock_thr`. A value below the threshold advances a run count, which saturates at `lock_need`. Any other value clears the run count. `locked` is 1 while the run count is at least `lock_need`, and it changes only on kept clocks.
- R7: After a start, each recorded sample makes `cap_we` high for one cycle, on the edge after the sample. `cap_addr` counts up from 0 and `cap_data` carries the difference. `cap_done` rises together with write number CAP_LEN.
- R8: While `cap_done` is set, recorded samples produce no write. `cap_start` clears `cap_done` and restarts at address 0, even in the middle of a capture. A sample that falls on the start cycle is not written.
- R9: After reset, `dac_word`, `locked`, `cap_we`, `cap_addr`, `cap_data` and `cap_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch1_in | input | 14 | Channel 1 sample, signed |
| ch2_in | input | 14 | Channel 2 sample, signed |
| div_m | input | 8 | Clocks per input period (0 treated as 1) |
| rec_peak | input | 1 | 0: record zero-crossing sample, 1: record peak sample |
| kp_shift | input | 4 | Proportional gain as right shift |
| ki_shift | input | 4 | Integral gain as right shift |
| lock_thr | input | 14 | Error magnitude limit for lock, unsigned |
| lock_need | input | 8 | Consecutive small errors required for lock |
| cap_start | input | 1 | One-cycle pulse starting a capture |
| dac_word | output | 14 | Signed correction word to the DAC |
| locked | output | 1 | Lock indication |
| cap_we | output | 1 | Capture memory write strobe |
| cap_addr | output | $clog2(CAP_LEN) | Capture memory address |
| cap_data | output | 15 | Channel difference to store, signed |
| cap_done | output | 1 | Capture complete |

## Verification
Random uncorrelated channel data in zero-point mode with M = 8 exercises the PI arithmetic and the recorded difference. This pattern separates a wrong channel or a wrong sign from a correct one. Full-scale positive and then negative constant errors with zero shifts drive both the integrator limits and the output clamp, which shows saturation apart from wrapping. Small errors with a single large spike show whether the lock run clears and then rebuilds. Peak-point runs at M = 4, 10 and 3, plus M = 0 and 1, separate the quarter-period offset from the locking point. Starts during and after a capture separate ignoring from restarting.

// File: rtl/psync_pkg.sv
package psync_pkg;
  typedef enum logic {
    REC_ZERO = 1'b0,
    REC_PEAK = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/psync_tick.sv
module psync_tick
  import psync_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] div_m,
  input  logic          rec_peak,
  output logic          zc_tick,
  output logic          rec_tick
);
  logic [MW-1:0] cnt_q, cnt_d, m_eff;

  always_comb begin
    m_eff = (div_m == '0) ? MW'(1) : div_m;
    cnt_d = (cnt_q >= m_eff - MW'(1)) ? '0 : cnt_q + MW'(1);
  end

  assign zc_tick  = (cnt_q == '0);
  assign rec_tick = (rec_mode_e'(rec_peak) == REC_PEAK) ? (cnt_q == (m_eff >> 2)) : zc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  zc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_tick && m_eff != MW'(1)) |=> !zc_tick);
endmodule

// File: rtl/psync_pi.sv
module psync_pi #(
  parameter int DW = 14,
  parameter int IW = 18,
  parameter int SW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] err,
  input  logic        [SW-1:0] kp_sh,
  input  logic        [SW-1:0] ki_sh,
  output logic signed [DW-1:0] dac
);
  localparam logic signed [IW:0] OMAX = (IW+1)'(2**(DW-1) - 1);
  localparam logic signed [IW:0] OMIN = (IW+1)'(-(2**(DW-1)));

  logic signed [IW-1:0] integ_q, integ_d, err_x, ierr, perr;
  logic signed [IW:0]   isum, osum;
  logic signed [DW-1:0] dac_d;

  always_comb begin
    err_x = IW'(err);
    ierr  = err_x >>> ki_sh;
    perr  = err_x >>> kp_sh;
    isum  = (IW+1)'(integ_q) + (IW+1)'(ierr);
    if (isum[IW] != isum[IW-1])
      integ_d = isum[IW] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
    else
      integ_d = isum[IW-1:0];
    osum = (IW+1)'(integ_d) + (IW+1)'(perr);
    if (osum > OMAX)      dac_d = {1'b0, {(DW-1){1'b1}}};
    else if (osum < OMIN) dac_d = {1'b1, {(DW-1){1'b0}}};
    else                  dac_d = osum[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      dac     <= '0;
    end else if (en) begin
      integ_q <= integ_d;
      dac     <= dac_d;
    end
  end

  // R2
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(dac));
endmodule

// File: rtl/psync_lock.sv
module psync_lock #(
  parameter int DW = 14,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] err,
  input  logic [DW-1:0] thr,
  input  logic [CW-1:0] need,
  output logic          locked
);
  logic [DW:0]   ext, mag;
  logic [CW-1:0] run_q, run_d;
  logic          lock_d;

  always_comb begin
    ext    = {err[DW-1], err};
    mag    = err[DW-1] ? (~ext + 1'b1) : ext;
    run_d  = (mag < {1'b0, thr}) ? ((run_q >= need) ? run_q : run_q + 1'b1) : '0;
    lock_d = (run_d >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      locked <= 1'b0;
    end else if (en) begin
      run_q  <= run_d;
      locked <= lock_d;
    end
  end

  // R6
  lock_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(locked));
endmodule

// File: rtl/psync_capture.sv
module psync_capture #(
  parameter int DW      = 14,
  parameter int CAP_LEN = 16384,
  parameter int AW      = $clog2(CAP_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          en,
  input  logic [DW:0]   diff,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [DW:0]   data,
  output logic          done
);
  localparam logic [AW-1:0] LAST = AW'(CAP_LEN - 1);

  logic          act_q, act_d, we_d, done_d;
  logic [AW-1:0] idx_q, idx_d, addr_d;
  logic [DW:0]   data_d;

  always_comb begin
    act_d  = act_q;
    idx_d  = idx_q;
    done_d = done;
    addr_d = addr;
    data_d = data;
    we_d   = 1'b0;
    if (start) begin
      act_d  = 1'b1;
      idx_d  = '0;
      done_d = 1'b0;
    end else if (act_q && en) begin
      we_d   = 1'b1;
      addr_d = idx_q;
      data_d = diff;
      if (idx_q == LAST) begin
        act_d  = 1'b0;
        done_d = 1'b1;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      we    <= 1'b0;
      addr  <= '0;
      data  <= '0;
      done  <= 1'b0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      we    <= we_d;
      addr  <= addr_d;
      data  <= data_d;
      done  <= done_d;
    end
  end

  // R7
  done_with_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (we && addr == LAST));
  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !we);
endmodule

// File: rtl/psync_sampler.sv
module psync_sampler #(
  parameter int DW      = 14,
  parameter int MW      = 8,
  parameter int SW      = 4,
  parameter int CW      = 8,
  parameter int IW      = DW + 4,
  parameter int CAP_LEN = 16384
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              ch1_in,
  input  logic [DW-1:0]              ch2_in,
  input  logic [MW-1:0]              div_m,
  input  logic                       rec_peak,
  input  logic [SW-1:0]              kp_shift,
  input  logic [SW-1:0]              ki_shift,
  input  logic [DW-1:0]              lock_thr,
  input  logic [CW-1:0]              lock_need,
  input  logic                       cap_start,
  output logic [DW-1:0]              dac_word,
  output logic                       locked,
  output logic                       cap_we,
  output logic [$clog2(CAP_LEN)-1:0] cap_addr,
  output logic [DW:0]                cap_data,
  output logic                       cap_done
);
  localparam int AW = $clog2(CAP_LEN);

  logic [1:0]  rs_q;
  logic        rst_ni, zc_tick, rec_tick;
  logic [DW:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign diff = {ch1_in[DW-1], ch1_in} - {ch2_in[DW-1], ch2_in};

  psync_tick #(.MW(MW)) u_tick (
    .clk(clk), .rst_n(rst_ni), .div_m(div_m), .rec_peak(rec_peak),
    .zc_tick(zc_tick), .rec_tick(rec_tick)
  );

  psync_pi #(.DW(DW), .IW(IW), .SW(SW)) u_pi (
    .clk(clk), .rst_n(rst_ni), .en(zc_tick), .err(ch1_in),
    .kp_sh(kp_shift), .ki_sh(ki_shift), .dac(dac_word)
  );

  psync_lock #(.DW(DW), .CW(CW)) u_lock (
    .clk(clk), .rst_n(rst_ni), .en(zc_tick), .err(ch1_in),
    .thr(lock_thr), .need(lock_need), .locked(locked)
  );

  psync_capture #(.DW(DW), .CAP_LEN(CAP_LEN), .AW(AW)) u_cap (
    .clk(clk), .rst_n(rst_ni), .start(cap_start), .en(rec_tick), .diff(diff),
    .we(cap_we), .addr(cap_addr), .data(cap_data), .done(cap_done)
  );
endmodule

// File: tb/sim_psync_sampler.sv
`timescale 1ns/1ps
module sim_psync_sampler;
  localparam int DW = 14, MW = 8, SW = 4, CW = 8, CAP_LEN = 32;
  localparam int AW = $clog2(CAP_LEN);
  localparam int IMAX = 131071, IMIN = -131072;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] ch1_in = '0, ch2_in = '0, lock_thr = '0;
  logic [MW-1:0] div_m = '0;
  logic rec_peak = 1'b0, cap_start = 1'b0;
  logic [SW-1:0] kp_shift = '0, ki_shift = '0;
  logic [CW-1:0] lock_need = '0;
  logic [DW-1:0] dac_word;
  logic locked, cap_we, cap_done;
  logic [AW-1:0] cap_addr;
  logic [DW:0] cap_data;

  integer vectors = 0, miscompares = 0;
  bit finished = 0;

  integer m_cnt, m_int, m_dac, m_run, m_lock, m_act, m_idx, m_we, m_addr, m_data, m_done, m_hold;

  always #10 clk = ~clk;

  psync_sampler #(.DW(DW), .MW(MW), .SW(SW), .CW(CW), .CAP_LEN(CAP_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .ch1_in(ch1_in), .ch2_in(ch2_in), .div_m(div_m),
    .rec_peak(rec_peak), .kp_shift(kp_shift), .ki_shift(ki_shift),
    .lock_thr(lock_thr), .lock_need(lock_need), .cap_start(cap_start),
    .dac_word(dac_word), .locked(locked), .cap_we(cap_we), .cap_addr(cap_addr),
    .cap_data(cap_data), .cap_done(cap_done)
  );

  task automatic model_reset();
    m_cnt = 0; m_int = 0; m_dac = 0; m_run = 0; m_lock = 0; m_act = 0;
    m_idx = 0; m_we = 0; m_addr = 0; m_data = 0; m_done = 0; m_hold = 2;
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (dac_word !== m_dac[DW-1:0]) begin
      miscompares++;
      $display("FAIL %s R1/R2/R3 dac_word actual %0d expected %0d", tag, $signed(dac_word), m_dac);
    end
    if (locked !== m_lock[0]) begin
      miscompares++;
      $display("FAIL %s R6 locked actual %0b expected %0d", tag, locked, m_lock);
    end
    if (cap_we !== m_we[0]) begin
      miscompares++;
      $display("FAIL %s R7/R8 cap_we actual %0b expected %0d", tag, cap_we, m_we);
    end
    if (cap_addr !== m_addr[AW-1:0]) begin
      miscompares++;
      $display("FAIL %s R7 cap_addr actual %0d expected %0d", tag, cap_addr, m_addr);
    end
    if (cap_data !== m_data[DW:0]) begin
      miscompares++;
      $display("FAIL %s R4/R5 cap_data actual %0d expected %0d", tag, $signed(cap_data), m_data);
    end
    if (cap_done !== m_done[0]) begin
      miscompares++;
      $display("FAIL %s R7/R8 cap_done actual %0b expected %0d", tag, cap_done, m_done);
    end
  endtask

  task automatic model_edge(input integer a, input integer b, input bit st);
    integer meff, e, i2, o, mag;
    bit zc, rec;
    if (m_hold > 0) begin
      m_hold--;
      return;
    end
    meff = (div_m == 0) ? 1 : int'(div_m);
    zc   = (m_cnt == 0);
    rec  = rec_peak ? (m_cnt == meff / 4) : zc;
    if (zc) begin
      e  = a;
      i2 = m_int + (e >>> ki_shift);
      if (i2 > IMAX) i2 = IMAX;
      if (i2 < IMIN) i2 = IMIN;
      m_int = i2;
      o = i2 + (e >>> kp_shift);
      if (o > 8191) o = 8191;
      if (o < -8192) o = -8192;
      m_dac = o;
      mag = (e < 0) ? -e : e;
      if (mag < int'(lock_thr)) begin
        if (m_run < int'(lock_need)) m_run++;
      end else m_run = 0;
      m_lock = (m_run >= int'(lock_need)) ? 1 : 0;
    end
    m_cnt = (m_cnt >= meff - 1) ? 0 : m_cnt + 1;
    m_we = 0;
    if (st) begin
      m_act = 1; m_idx = 0; m_done = 0;
    end else if (m_act == 1 && rec) begin
      m_we = 1; m_addr = m_idx; m_data = a - b;
      if (m_idx == CAP_LEN - 1) begin
        m_act = 0; m_done = 1; m_idx = 0;
      end else m_idx++;
    end
  endtask

  // Called just after a falling edge; returns at the next falling edge.
  task automatic step(input integer a, input integer b, input bit st, input string tag);
    compare(tag);
    ch1_in = a[DW-1:0];
    ch2_in = b[DW-1:0];
    cap_start = st;
    model_edge(a, b, st);
    @(negedge clk);
  endtask

  function automatic integer rnd(input integer span);
    rnd = int'($urandom_range(2 * span)) - span;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    // R9: outputs held at zero while reset is asserted
    repeat (3) begin
      @(negedge clk);
      compare("R9 reset");
    end
    rst_n = 1'b1;
    // R9: release is synchronised over two edges, outputs stay zero
    step(0, 0, 0, "R9 release");
    step(0, 0, 0, "R9 release");

    // R2 R5 R7: zero-point recording, M=8, random data, capture past the end
    div_m = 8; rec_peak = 0; kp_shift = 2; ki_shift = 4; lock_thr = 200; lock_need = 4;
    step(rnd(8000), rnd(8000), 1, "R7 start");
    for (int k = 0; k < 300; k++) step(rnd(8192), rnd(8192), 0, "R2/R5 phase M8");
    // R8: done is set here, further kept samples must not write
    for (int k = 0; k < 40; k++) step(rnd(8192), rnd(8192), 0, "R8 ignore");

    // R6: small errors, one spike, then small again
    div_m = 2; lock_thr = 100; lock_need = 5;
    for (int k = 0; k < 30; k++) step(rnd(99), rnd(50), 0, "R6 small");
    step(5000, 0, 0, "R6 spike");
    step(5000, 0, 0, "R6 spike");
    for (int k = 0; k < 30; k++) step(rnd(99), rnd(50), 0, "R6 rebuild");
    step(100, 0, 0, "R6 at threshold");
    step(100, 0, 0, "R6 at threshold");
    step(-99, 0, 0, "R6 below");
    step(-99, 0, 0, "R6 below");

    // R3: saturation with full-scale constant errors, M=1
    div_m = 1; kp_shift = 0; ki_shift = 0;
    for (int k = 0; k < 40; k++) step(8191, 0, 0, "R3 positive");
    for (int k = 0; k < 80; k++) step(-8192, 8191, 0, "R3 negative");
    for (int k = 0; k < 10; k++) step(rnd(8192), rnd(8192), 0, "R3 release");

    // R4: peak recording at M=4, restart capture
    div_m = 4; rec_peak = 1; kp_shift = 3; ki_shift = 6;
    step(0, 0, 1, "R8 restart");
    for (int k = 0; k < 150; k++) step(rnd(8192), rnd(8192), 0, "R4 peak M4");

    // R4: peak offset floor(10/4)=2, and M=3 where it meets the zero point
    div_m = 10;
    step(0, 0, 1, "R8 restart");
    for (int k = 0; k < 200; k++) step(rnd(8192), rnd(8192), 0, "R4 peak M10");
    div_m = 3;
    step(0, 0, 1, "R8 restart");
    for (int k = 0; k < 60; k++) step(rnd(8192), rnd(8192), 0, "R4 peak M3");

    // R1: M=0 acts as 1; R8 start mid-capture and on a recorded cycle
    div_m = 0; rec_peak = 0;
    step(1, 2, 1, "R1 M0 start");
    for (int k = 0; k < 10; k++) step(rnd(8192), rnd(8192), 0, "R1 M0");
    step(3, 4, 1, "R8 mid restart");
    for (int k = 0; k < 45; k++) step(rnd(8192), rnd(8192), 0, "R7 full M0");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule